// File: doc/BRIEF.md
# I2C Address and Data Match Trigger

This block listens passively to the two wires of an I2C bus. It never drives them. It brings both lines into the local clock domain and finds the START and STOP conditions. It then recovers every transferred byte together with the acknowledge bit that follows it. Each byte is presented on a parallel output with a one-cycle strobe. The output marks whether the byte was the address byte and gives the value of its ninth bit.

The block also fires a one-cycle trigger pulse when all of the following are true:

- The address byte names a programmed 7-bit target.
- The address byte is acknowledged.
- Its direction bit is accepted by the programmed direction mode.
- The first data byte after it equals a programmed value.

Typical use is to freeze a logic capture, or to flag a transaction of interest, while a debug session is running. Because the block only samples the lines, a slave that holds SCL low simply lengthens the bit and needs no special treatment.

Top module: `i2c_match_trigger`

## Requirements
- R1: After reset, `trig`, `byte_valid`, `start_det` and `stop_det` are low, and no byte is reported until a START has been seen.
- R2: A falling SDA while SCL is high raises `start_det` for one cycle. A rising SDA while SCL is high raises `stop_det` for one cycle.
- R3: Data bits are taken on rising SCL edges, most significant bit first. On the rising edge of the ninth bit, `byte_valid` pulses for one cycle. At the same time `byte_out` holds the eight bits, `ack_out` holds the ninth bit (0 = acknowledge, 1 = not acknowledged), and `first_byte` is 1 only for the address byte of the transaction.
- R4: SCL pulses outside a transaction (before the first START or after a STOP) produce no reported byte.
- R5: `trig` pulses when both of these hold: the address byte's upper seven bits equal `cfg_addr`, and the first data byte equals `cfg_data`. The pulse lands in the same cycle as that data byte's `byte_valid`, at which point `byte_out` equals `cfg_data`.
- R6: Only the first data byte after the address is compared. A matching value in any later byte of the same transaction never triggers.
- R7: `cfg_dir` selects the direction filter on address bit 0 (0 = write, 1 = read). The codes are 2'b01 for write only, 2'b10 for read only, and 2'b00 or 2'b11 for either direction.
- R8: If the address byte's ninth bit is 1, no trigger is possible in that transaction, but its bytes are still reported.
- R9: A repeated START discards any partly received byte and begins a fresh address phase, which re-arms the trigger.
- R10: `trig` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Observed SCL line |
| sda_in | input | 1 | Observed SDA line |
| cfg_addr | input | 7 | Target 7-bit address |
| cfg_data | input | 8 | Target first data byte |
| cfg_dir | input | 2 | Direction filter mode |
| trig | output | 1 | One-cycle match pulse |
| byte_out | output | 8 | Last decoded byte |
| byte_valid | output | 1 | Strobe for byte_out, ack_out and first_byte |
| first_byte | output | 1 | Reported byte is the address byte |
| ack_out | output | 1 | Ninth bit of the reported byte |
| start_det | output | 1 | START or repeated START seen |
| stop_det | output | 1 | STOP seen |

## Verification
The bench aims at several cases that a plausible decoder gets wrong:

- A matching value placed in the second data byte. A decoder that compares every byte would fire here.
- A NACKed address. A decoder that ignores the ninth bit would still fire.
- A repeated START after three stray bits. A decoder that keeps its bit counter would misalign every following byte and miss the match.
- A repeated START after a non-matching data byte. A decoder that disarms until STOP would stay silent where it should fire.
- Clocked bits after a STOP. These would leak out as phantom bytes from a decoder that does not gate on an open transaction.
- Both direction filters, with read and write addresses.

// File: rtl/i2c_match_trigger.sv
module i2c_match_trigger #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [1:0]        cfg_dir,
  output logic              trig,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_valid,
  output logic              first_byte,
  output logic              ack_out,
  output logic              start_det,
  output logic              stop_det
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(DATA_W);

  typedef enum logic [1:0] {PH_ADDR, PH_DATA0, PH_REST} phase_t;

  logic [SYNC_STAGES:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_s, sda_d;
  logic start_c, stop_c, scl_rise, dir_ok;
  logic active, addr_hit;
  logic [CNT_W-1:0] bit_cnt;
  logic [DATA_W-1:0] shreg;
  phase_t phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-1:0], scl_in};
      sda_p <= {sda_p[SYNC_STAGES-1:0], sda_in};
    end

  assign scl_s    = scl_p[SYNC_STAGES-1];
  assign scl_d    = scl_p[SYNC_STAGES];
  assign sda_s    = sda_p[SYNC_STAGES-1];
  assign sda_d    = sda_p[SYNC_STAGES];
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;

  always_comb
    case (cfg_dir)
      2'b01:   dir_ok = ~shreg[0];
      2'b10:   dir_ok = shreg[0];
      default: dir_ok = 1'b1;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active     <= 1'b0;
      addr_hit   <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      phase      <= PH_ADDR;
      trig       <= 1'b0;
      byte_out   <= '0;
      byte_valid <= 1'b0;
      first_byte <= 1'b0;
      ack_out    <= 1'b0;
      start_det  <= 1'b0;
      stop_det   <= 1'b0;
    end else begin
      trig       <= 1'b0;
      byte_valid <= 1'b0;
      start_det  <= start_c;
      stop_det   <= stop_c;
      if (start_c) begin
        active   <= 1'b1;
        bit_cnt  <= '0;
        phase    <= PH_ADDR;
        addr_hit <= 1'b0;
      end else if (stop_c) begin
        active <= 1'b0;
      end else if (active && scl_rise) begin
        if (bit_cnt != ACK_POS) begin
          shreg   <= {shreg[DATA_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          bit_cnt    <= '0;
          byte_valid <= 1'b1;
          byte_out   <= shreg;
          ack_out    <= sda_s;
          first_byte <= (phase == PH_ADDR);
          case (phase)
            PH_ADDR: begin
              addr_hit <= (shreg[DATA_W-1:1] == cfg_addr) && dir_ok && !sda_s;
              phase    <= PH_DATA0;
            end
            PH_DATA0: begin
              trig  <= addr_hit && (shreg == cfg_data);
              phase <= PH_REST;
            end
            default: ;
          endcase
        end
      end
    end
endmodule

module i2c_match_trigger_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_data,
  input logic              trig,
  input logic [DATA_W-1:0] byte_out,
  input logic              byte_valid,
  input logic              first_byte,
  input logic              start_det,
  input logic              stop_det
);
  a_r10_trig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig);
  a_r5_trig_on_data_byte: assert property (@(posedge clk) disable iff (!rst_n) trig |-> (byte_valid && !first_byte));
  a_r5_trig_value: assert property (@(posedge clk) disable iff (!rst_n) trig |-> (byte_out == cfg_data));
  a_r2_start_stop_apart: assert property (@(posedge clk) disable iff (!rst_n) !(start_det && stop_det));
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n) byte_valid |=> !byte_valid);
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> !start_det);
endmodule

bind i2c_match_trigger i2c_match_trigger_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .trig(trig), .byte_out(byte_out),
  .byte_valid(byte_valid), .first_byte(first_byte), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/sim_i2c_match_trigger.sv
module sim_i2c_match_trigger;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [6:0] cfg_addr = 7'h50;
  logic [7:0] cfg_data = 8'h00;
  logic [1:0] cfg_dir = 2'b00;
  logic trig, byte_valid, first_byte, ack_out, start_det, stop_det;
  logic [7:0] byte_out;

  int checks = 0, errors = 0;
  bit done = 0;
  int nb = 0, ntrig = 0, trig_at = -1, nstart = 0, nstop = 0, dbl = 0;
  logic [7:0] vb [16];
  logic va [16];
  logic vf [16];
  logic prev_trig = 1'b0;

  always #10 clk = ~clk;

  i2c_match_trigger u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_dir(cfg_dir),
    .trig(trig), .byte_out(byte_out), .byte_valid(byte_valid),
    .first_byte(first_byte), .ack_out(ack_out),
    .start_det(start_det), .stop_det(stop_det)
  );

  always @(negedge clk) begin
    if (byte_valid && nb < 16) begin
      vb[nb] = byte_out; va[nb] = ack_out; vf[nb] = first_byte;
    end
    if (trig) begin
      ntrig++;
      trig_at = byte_valid ? nb : -2;
    end
    if (trig && prev_trig) dbl++;
    prev_trig = trig;
    if (byte_valid) nb++;
    if (start_det) nstart++;
    if (stop_det) nstop++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    nb = 0; ntrig = 0; trig_at = -1; nstart = 0; nstop = 0;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda = 1'b1; wt(H); scl = 1'b1; wt(H); sda = 1'b0; wt(H); scl = 1'b0; wt(H);
  endtask

  task automatic i2c_stop();
    scl = 1'b0; sda = 1'b0; wt(H); scl = 1'b1; wt(H); sda = 1'b1; wt(2 * H);
  endtask

  task automatic send_bit(input logic b);
    scl = 1'b0; sda = b; wt(H); scl = 1'b1; wt(2 * H); scl = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    send_bit(ack);
  endtask

  task automatic t_reset();
    chk(trig === 1'b0 && byte_valid === 1'b0, "R1 trig/valid after reset", trig, 0);
    chk(start_det === 1'b0 && stop_det === 1'b0, "R1 flags after reset", start_det, 0);
    chk(nb == 0, "R1 no bytes before START", nb, 0);
  endtask

  task automatic t_write_match();
    clr();
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(nstart == 1, "R2 start_det count", nstart, 1);
    chk(nstop == 1, "R2 stop_det count", nstop, 1);
    chk(nb == 2, "R3 byte count", nb, 2);
    chk(vb[0] == 8'hA0 && vf[0] == 1'b1 && va[0] == 1'b0, "R3 address byte", vb[0], 8'hA0);
    chk(vb[1] == 8'h00 && vf[1] == 1'b0, "R3 data byte", vb[1], 0);
    chk(ntrig == 1, "R5 trigger on match", ntrig, 1);
    chk(trig_at == 1, "R5 trigger with data byte strobe", trig_at, 1);
  endtask

  task automatic t_msb_order();
    clr(); cfg_data = 8'h96;
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h96, 1'b1); send_byte(8'h3C, 1'b1); i2c_stop();
    chk(vb[1] == 8'h96 && va[1] == 1'b1, "R3 msb first and ninth bit", vb[1], 8'h96);
    chk(vb[2] == 8'h3C, "R3 third byte", vb[2], 8'h3C);
    chk(ntrig == 1, "R5 match with nacked data byte", ntrig, 1);
    cfg_data = 8'h00;
  endtask

  task automatic t_data_mismatch();
    clr();
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h01, 1'b0); i2c_stop();
    chk(ntrig == 0, "R5 no trigger on data mismatch", ntrig, 0);
    clr();
    i2c_start(); send_byte(8'hA2, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(ntrig == 0, "R5 no trigger on address mismatch", ntrig, 0);
  endtask

  task automatic t_later_byte();
    clr();
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h11, 1'b0);
    send_byte(8'h00, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(nb == 4, "R6 all bytes reported", nb, 4);
    chk(ntrig == 0, "R6 later matching byte ignored", ntrig, 0);
  endtask

  task automatic t_addr_nack();
    clr();
    i2c_start(); send_byte(8'hA0, 1'b1); send_byte(8'h00, 1'b0); i2c_stop();
    chk(ntrig == 0, "R8 nacked address blocks trigger", ntrig, 0);
    chk(nb == 2 && va[0] == 1'b1, "R8 bytes still reported", nb, 2);
  endtask

  task automatic t_dir();
    clr(); cfg_dir = 2'b01;
    i2c_start(); send_byte(8'hA1, 1'b0); send_byte(8'h00, 1'b1); i2c_stop();
    chk(ntrig == 0, "R7 write-only rejects read", ntrig, 0);
    clr();
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(ntrig == 1, "R7 write-only accepts write", ntrig, 1);
    clr(); cfg_dir = 2'b10;
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(ntrig == 0, "R7 read-only rejects write", ntrig, 0);
    clr();
    i2c_start(); send_byte(8'hA1, 1'b0); send_byte(8'h00, 1'b1); i2c_stop();
    chk(ntrig == 1, "R7 read-only accepts read", ntrig, 1);
    clr(); cfg_dir = 2'b11;
    i2c_start(); send_byte(8'hA1, 1'b0); send_byte(8'h00, 1'b1); i2c_stop();
    chk(ntrig == 1, "R7 mode 3 accepts read", ntrig, 1);
    cfg_dir = 2'b00;
  endtask

  task automatic t_repeated_start();
    clr();
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h11, 1'b0);
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(nstart == 2, "R9 repeated start flagged", nstart, 2);
    chk(ntrig == 1 && trig_at == 3, "R9 re-armed after repeated start", trig_at, 3);
    chk(vf[2] == 1'b1, "R9 new address phase", vf[2], 1);
    clr();
    i2c_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start(); send_byte(8'hA0, 1'b0); send_byte(8'h00, 1'b0); i2c_stop();
    chk(nb == 2 && vb[0] == 8'hA0, "R9 partial bits discarded", vb[0], 8'hA0);
    chk(ntrig == 1, "R9 trigger after partial byte", ntrig, 1);
  endtask

  task automatic t_idle_bits();
    clr();
    for (int i = 0; i < 18; i++) send_bit(i[0]);
    i2c_stop();
    chk(nb == 0, "R4 no bytes outside transaction", nb, 0);
    chk(ntrig == 0, "R4 no trigger outside transaction", ntrig, 0);
  endtask

  initial begin
    wt(5);
    t_reset();
    rst_n = 1'b1;
    wt(10);
    t_idle_bits();
    t_write_match();
    t_msb_order();
    t_data_mismatch();
    t_later_byte();
    t_addr_nack();
    t_dir();
    t_repeated_start();
    t_idle_bits();
    chk(dbl == 0, "R10 trig never two cycles", dbl, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule